// File: doc/BRIEF.md
# Split Write Data-Error Responder

This block sits beside the target side of a split-transaction bus interface. It reacts to uncorrectable data errors found during configuration writes. The write data is still accepted and the transaction still ends with a split response termination. After that, the block decides what follows. It can drive a delayed, active-low parity-error pulse. It can request a split completion error message back to the original requester. It can stop the failed write from reaching the internal bus. It also keeps sticky status and interrupt-status bits, and it strobes the ECC logging registers in mode 2.

Each termination arrives as a one-cycle strobe. The strobe comes with an error flag, the requester identifier and a mode-2 flag. A control input enables the parity-error response, and two mask inputs gate the interrupt-status bits. The message transmitter is reached through a request/acknowledge handshake. Requests waiting for the transmitter sit in a small in-order queue, so that errors arriving back to back are not lost.

Top module: `split_wr_err_responder`

## Requirements
- R1: After reset, `perr_n` is 1, and `msg_req`, `fwd_valid`, `ecc_log_stb`, `sts_dpe`, `isr_dpe` and `isr_scem` are all 0.
- R2: A termination with `term_err`=1 in cycle T, while `ctl_perr_resp`=1, drives `perr_n` low for exactly cycle T+3. Errors in consecutive cycles each get their own pulse.
- R3: A termination with `term_err`=1 while `ctl_perr_resp`=0 produces no `perr_n` pulse, no message request and no change to `isr_scem`.
- R4: Every `perr_n` pulse queues one message. From the next cycle on, `msg_req` is 1 with `msg_class`=4'h2 (completer error), `msg_index`=8'h01 (uncorrectable split write data) and `msg_req_id` equal to `term_req_id` as captured in cycle T. The request and its identifier are held until `msg_ack`=1. Queued messages leave in arrival order, and up to 4 can wait.
- R5: `fwd_valid` pulses in cycle T+1 for every termination in cycle T, except one that has `term_err`=1 while `ctl_perr_resp`=1.
- R6: `sts_dpe` becomes 1 in cycle T+1 for every termination with `term_err`=1, whatever the value of `ctl_perr_resp`.
- R7: `isr_dpe` becomes 1 together with `sts_dpe` when `msk_dpe`=0. When `msk_dpe`=1, the error leaves `isr_dpe` unchanged.
- R8: In the cycle after a `perr_n` pulse, `isr_scem` becomes 1 if `msk_scem`=0 during the pulse. When the mask is 1, `isr_scem` is left unchanged.
- R9: `ecc_log_stb` pulses in cycle T+1 for a termination with `term_err`=1 and `mode2`=1. It stays 0 when `mode2`=0.
- R10: The three status bits are sticky. A 1 on `clr_sts_dpe`, `clr_isr_dpe` or `clr_isr_scem` clears the matching bit from the next cycle on. If a set and a clear of the same bit fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_valid | input | 1 | Split response termination of a configuration write this cycle |
| term_err | input | 1 | Uncorrectable data error detected on that write |
| term_req_id | input | RID_W | Requester identifier of the write |
| mode2 | input | 1 | Bus runs in mode 2 |
| ctl_perr_resp | input | 1 | Parity-error response enable |
| msk_scem | input | 1 | Mask for the initiated-error-message interrupt status |
| msk_dpe | input | 1 | Mask for the detected-parity interrupt status |
| clr_sts_dpe | input | 1 | Write-one-to-clear for `sts_dpe` |
| clr_isr_dpe | input | 1 | Write-one-to-clear for `isr_dpe` |
| clr_isr_scem | input | 1 | Write-one-to-clear for `isr_scem` |
| msg_ack | input | 1 | Message transmitter accepts the current request |
| perr_n | output | 1 | Active-low parity-error pulse |
| msg_req | output | 1 | Error-message request pending |
| msg_class | output | 4 | Message class |
| msg_index | output | 8 | Message index |
| msg_req_id | output | RID_W | Requester the message is addressed to |
| fwd_valid | output | 1 | Forward the write to the internal bus |
| ecc_log_stb | output | 1 | Update strobe for the ECC logging registers |
| sts_dpe | output | 1 | Detected-parity-error status (sticky) |
| isr_dpe | output | 1 | Detected-parity interrupt status (sticky) |
| isr_scem | output | 1 | Initiated-error-message interrupt status (sticky) |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a new error termination arriving in the very cycle the parity-error pulse of an earlier error is on `perr_n`. The bench provokes it with four errors in consecutive cycles while acknowledging messages with stalls. The scoreboard then expects four separate pulses and four messages, in order and with the right identifiers. The second pair is a set and a write-one-to-clear of the same sticky bit in one cycle. The bench provokes it by driving `clr_sts_dpe` and `clr_isr_dpe` alongside an error termination, and the status model expects both bits to stay 1.

// File: rtl/swe_pkg.sv
package swe_pkg;
  localparam int         PERR_DELAY = 3;
  localparam logic [3:0] MSG_CLASS_COMPLETER_ERR = 4'h2;
  localparam logic [7:0] MSG_INDEX_SPLIT_WR_DATA = 8'h01;
  localparam int         NUM_STICKY = 3;
  localparam int         STK_DPE    = 0;
  localparam int         STK_IDPE   = 1;
  localparam int         STK_ISCEM  = 2;
endpackage

// File: rtl/swe_delay_line.sv
module swe_delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [W-1:0]     dat_q [DEPTH];
  logic [W-1:0]     dat_d [DEPTH];

  always_comb begin
    vld_d[0] = in_vld;
    dat_d[0] = in_vld ? in_dat : dat_q[0];
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_comb begin
      vld_d[s] = vld_q[s-1];
      dat_d[s] = vld_q[s-1] ? dat_q[s-1] : dat_q[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < DEPTH; s++) dat_q[s] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int s = 0; s < DEPTH; s++) dat_q[s] <= dat_d[s];
    end
  end

  assign out_vld = vld_q[DEPTH-1];
  assign out_dat = dat_q[DEPTH-1];
endmodule

// File: rtl/swe_msg_queue.sv
module swe_msg_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_dat,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem_q[rd_q];

  always_comb begin
    wr_d  = push_ok ? wr_q + 1'b1 : wr_q;
    rd_d  = pop_ok  ? rd_q + 1'b1 : rd_q;
    cnt_d = cnt_q + {{AW{1'b0}}, push_ok} - {{AW{1'b0}}, pop_ok};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      if (push_ok) mem_q[wr_q] <= push_dat;
    end
  end
endmodule

// File: rtl/swe_sticky_bit.sv
module swe_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (clr) q_d = 1'b0;
    if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/split_wr_err_responder.sv
module split_wr_err_responder
  import swe_pkg::*;
#(
  parameter int RID_W  = 16,
  parameter int QDEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             term_valid,
  input  logic             term_err,
  input  logic [RID_W-1:0] term_req_id,
  input  logic             mode2,
  input  logic             ctl_perr_resp,
  input  logic             msk_scem,
  input  logic             msk_dpe,
  input  logic             clr_sts_dpe,
  input  logic             clr_isr_dpe,
  input  logic             clr_isr_scem,
  input  logic             msg_ack,
  output logic             perr_n,
  output logic             msg_req,
  output logic [3:0]       msg_class,
  output logic [7:0]       msg_index,
  output logic [RID_W-1:0] msg_req_id,
  output logic             fwd_valid,
  output logic             ecc_log_stb,
  output logic             sts_dpe,
  output logic             isr_dpe,
  output logic             isr_scem
);
  logic             err_hit, perr_arm;
  logic             dl_vld;
  logic [RID_W-1:0] dl_id;
  logic             q_push, q_pop, q_empty, q_full;
  logic             fwd_q, fwd_d, ecc_q, ecc_d;
  logic [NUM_STICKY-1:0] stk_set, stk_clr, stk_q;

  assign err_hit  = term_valid && term_err;
  assign perr_arm = err_hit && ctl_perr_resp;

  // Pulse timing: the armed error walks through PERR_DELAY stages
  swe_delay_line #(.W(RID_W), .DEPTH(PERR_DELAY)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (perr_arm),
    .in_dat  (term_req_id),
    .out_vld (dl_vld),
    .out_dat (dl_id)
  );

  assign perr_n = !dl_vld;

  // Message requests wait here for the transmitter
  assign q_push = dl_vld;
  assign q_pop  = msg_ack && msg_req;

  swe_msg_queue #(.W(RID_W), .DEPTH(QDEPTH)) u_msgq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (q_push),
    .push_dat (dl_id),
    .pop      (q_pop),
    .empty    (q_empty),
    .full     (q_full),
    .head     (msg_req_id)
  );

  assign msg_req   = !q_empty;
  assign msg_class = MSG_CLASS_COMPLETER_ERR;
  assign msg_index = MSG_INDEX_SPLIT_WR_DATA;

  // Forwarding and ECC logging strobes
  always_comb begin
    fwd_d = term_valid && !perr_arm;
    ecc_d = err_hit && mode2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q <= 1'b0;
      ecc_q <= 1'b0;
    end else begin
      fwd_q <= fwd_d;
      ecc_q <= ecc_d;
    end
  end

  assign fwd_valid   = fwd_q;
  assign ecc_log_stb = ecc_q;

  // Sticky status bits
  always_comb begin
    stk_set[STK_DPE]   = err_hit;
    stk_set[STK_IDPE]  = err_hit && !msk_dpe;
    stk_set[STK_ISCEM] = dl_vld && !msk_scem;
    stk_clr[STK_DPE]   = clr_sts_dpe;
    stk_clr[STK_IDPE]  = clr_isr_dpe;
    stk_clr[STK_ISCEM] = clr_isr_scem;
  end

  for (genvar b = 0; b < NUM_STICKY; b++) begin : g_sticky
    swe_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (stk_set[b]),
      .clr   (stk_clr[b]),
      .q     (stk_q[b])
    );
  end

  assign sts_dpe  = stk_q[STK_DPE];
  assign isr_dpe  = stk_q[STK_IDPE];
  assign isr_scem = stk_q[STK_ISCEM];
endmodule

// File: rtl/swe_checker.sv
module swe_checker #(
  parameter int RID_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             term_valid,
  input logic             term_err,
  input logic             ctl_perr_resp,
  input logic             msk_scem,
  input logic             clr_sts_dpe,
  input logic             msg_ack,
  input logic             perr_n,
  input logic             msg_req,
  input logic [RID_W-1:0] msg_req_id,
  input logic             fwd_valid,
  input logic             sts_dpe,
  input logic             isr_scem,
  input logic             q_push,
  input logic             q_full
);
  logic armed;
  assign armed = term_valid && term_err && ctl_perr_resp;

  AST_PERR_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ##2 !perr_n); // R2
  AST_PERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(armed, 3)); // R3
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && !msg_ack) |=> (msg_req && $stable(msg_req_id))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_push && q_full)); // R4
  AST_NO_FWD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> !fwd_valid); // R5
  AST_DPE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (term_valid && term_err) |=> sts_dpe); // R6
  AST_SCEM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr_scem) |-> $past(!perr_n && !msk_scem)); // R8
  AST_DPE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_dpe) |-> $past(clr_sts_dpe)); // R10
endmodule

bind split_wr_err_responder swe_checker #(.RID_W(RID_W)) u_swe_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .term_valid    (term_valid),
  .term_err      (term_err),
  .ctl_perr_resp (ctl_perr_resp),
  .msk_scem      (msk_scem),
  .clr_sts_dpe   (clr_sts_dpe),
  .msg_ack       (msg_ack),
  .perr_n        (perr_n),
  .msg_req       (msg_req),
  .msg_req_id    (msg_req_id),
  .fwd_valid     (fwd_valid),
  .sts_dpe       (sts_dpe),
  .isr_scem      (isr_scem),
  .q_push        (q_push),
  .q_full        (q_full)
);

// File: tb/split_wr_err_responder_bench.sv
`timescale 1ns/1ps
module split_wr_err_responder_bench;
  localparam int NCYC = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t_valid = 1'b0, t_err = 1'b0, t_m2 = 1'b0;
  logic [15:0] t_id = '0;
  logic pre = 1'b1, mskS = 1'b0, mskD = 1'b0;
  logic clrS = 1'b0, clrI = 1'b0, clrC = 1'b0;
  logic msg_ack = 1'b0;
  logic perr_n, msg_req, fwd_valid, ecc_log_stb, sts_dpe, isr_dpe, isr_scem;
  logic [3:0]  msg_class;
  logic [7:0]  msg_index;
  logic [15:0] msg_req_id;

  int checks = 0, fails = 0, cyc = 0;
  bit mon_en = 0;
  bit exp_perr [NCYC], exp_fwd [NCYC], exp_ecc [NCYC];
  bit set_dpe [NCYC], set_idpe [NCYC], set_scem [NCYC];
  bit clr_dpe [NCYC], clr_idpe [NCYC], clr_scem [NCYC];
  bit m_dpe = 0, m_idpe = 0, m_scem = 0;
  logic [15:0] exp_q [$];

  always #2.5 clk = ~clk;

  split_wr_err_responder u_split_wr_err_responder (
    .clk(clk), .rst_n(rst_n), .term_valid(t_valid), .term_err(t_err),
    .term_req_id(t_id), .mode2(t_m2), .ctl_perr_resp(pre), .msk_scem(mskS),
    .msk_dpe(mskD), .clr_sts_dpe(clrS), .clr_isr_dpe(clrI), .clr_isr_scem(clrC),
    .msg_ack(msg_ack), .perr_n(perr_n), .msg_req(msg_req), .msg_class(msg_class),
    .msg_index(msg_index), .msg_req_id(msg_req_id), .fwd_valid(fwd_valid),
    .ecc_log_stb(ecc_log_stb), .sts_dpe(sts_dpe), .isr_dpe(isr_dpe), .isr_scem(isr_scem)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Driver: one call is one cycle; expectations are pushed into the scoreboard
  task automatic drive(input logic v, input logic e, input logic [15:0] id,
                       input logic m2, input logic cs, input logic ci, input logic cc);
    int c;
    c = cyc;
    t_valid = v; t_err = e; t_id = id; t_m2 = m2;
    clrS = cs; clrI = ci; clrC = cc;
    if (v) begin
      if (!(e && pre)) exp_fwd[c+1] = 1;
      if (e) begin
        set_dpe[c+1] = 1;
        if (!mskD) set_idpe[c+1] = 1;
        if (m2) exp_ecc[c+1] = 1;
        if (pre) begin
          exp_perr[c+3] = 1;
          if (!mskS) set_scem[c+4] = 1;
          exp_q.push_back(id);
        end
      end
    end
    if (cs) clr_dpe[c+1] = 1;
    if (ci) clr_idpe[c+1] = 1;
    if (cc) clr_scem[c+1] = 1;
    @(negedge clk);
    t_valid = 0; t_err = 0; clrS = 0; clrI = 0; clrC = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 16'h0, 0, 0, 0, 0);
  endtask

  // Monitor: compares outputs against the scoreboard every cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (set_dpe[cyc]) m_dpe = 1; else if (clr_dpe[cyc]) m_dpe = 0;
      if (set_idpe[cyc]) m_idpe = 1; else if (clr_idpe[cyc]) m_idpe = 0;
      if (set_scem[cyc]) m_scem = 1; else if (clr_scem[cyc]) m_scem = 0;
      chk("R2/R3 perr_n", perr_n, !exp_perr[cyc]);
      chk("R5 fwd_valid", fwd_valid, exp_fwd[cyc]);
      chk("R9 ecc_log_stb", ecc_log_stb, exp_ecc[cyc]);
      chk("R6/R10 sts_dpe", sts_dpe, m_dpe);
      chk("R7/R10 isr_dpe", isr_dpe, m_idpe);
      chk("R8/R10 isr_scem", isr_scem, m_scem);
      if (msg_req && (cyc % 3 != 2)) begin
        msg_ack = 1;
        if (exp_q.size() == 0) chk("R3 unexpected message", 1, 0);
        else begin
          chk("R4 msg_req_id", msg_req_id, exp_q[0]);
          chk("R4 msg_class", msg_class, 4'h2);
          chk("R4 msg_index", msg_index, 8'h01);
          void'(exp_q.pop_front());
        end
      end else begin
        msg_ack = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 perr_n", perr_n, 1);
    chk("R1 msg_req", msg_req, 0);
    chk("R1 fwd_valid", fwd_valid, 0);
    chk("R1 ecc_log_stb", ecc_log_stb, 0);
    chk("R1 status", {sts_dpe, isr_dpe, isr_scem}, 0);
    rst_n = 1;
    @(negedge clk);
    mon_en = 1;
    idle(3);
    // R2 R4 R6 R7 R8 R9: single error, response on, mode 2
    drive(1, 1, 16'hA001, 1, 0, 0, 0);
    idle(10);
    // R5: clean write forwarded
    drive(1, 0, 16'h0B0B, 1, 0, 0, 0);
    idle(4);
    // R10: clear all bits
    drive(0, 0, 16'h0, 0, 1, 1, 1);
    idle(3);
    // R3 R5 R6 R9: response off, mode 1
    pre = 0;
    drive(1, 1, 16'hC003, 0, 0, 0, 0);
    idle(10);
    pre = 1;
    drive(0, 0, 16'h0, 0, 1, 1, 1);
    idle(3);
    // R7 R8: both masks set, interrupt status stays clear
    mskD = 1; mskS = 1;
    drive(1, 1, 16'hD004, 1, 0, 0, 0);
    idle(10);
    mskD = 0; mskS = 0;
    // R2 R4: four errors back to back, the last one during the first pulse
    drive(1, 1, 16'h1111, 0, 0, 0, 0);
    drive(1, 1, 16'h2222, 1, 0, 0, 0);
    drive(1, 1, 16'h3333, 0, 0, 0, 0);
    drive(1, 1, 16'h4444, 1, 0, 0, 0);
    idle(14);
    // R10: set and clear in the same cycle, set wins
    drive(1, 1, 16'h5555, 0, 1, 1, 0);
    idle(10);
    drive(0, 0, 16'h0, 0, 1, 1, 1);
    idle(4);
    chk("R4 all messages delivered", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule